// File: doc/BRIEF.md
# 1-Wire Bus Master Engine

This block is a synchronous master for a single-wire, open-drain bus. A request selects one of three actions: a bus reset with a check for a presence pulse, a one-bit write slot, or a one-bit read slot. The master pulls the line low only through an active-low pull-down enable. It reads the bus through a two-flop synchronizer. Every pulse width, sample point and recovery gap is a clock-count parameter. There are two full timing sets, one for standard speed and one for overdrive. A per-request speed flag picks the set.

A request is taken only while the engine is idle. The engine holds `busy` for the whole waveform, including the recovery gap. It then raises `done` for one cycle. At that point `presence` (after a reset) or `rd_bit` (after a read) holds the sampled result. The standard-speed reset low time is long enough to return slaves to standard speed. The overdrive reset low time is short enough to keep them in overdrive. An optional mixed-network setting stretches the post-reset high window to a per-speed floor, so that slower slaves also get time to respond.

States: `ST_IDLE`, `ST_RST_LOW`, `ST_RST_HIGH`, `ST_SLOT_LOW`, `ST_SLOT_HIGH` and `ST_RECOVER`. The transitions are:
- `ST_IDLE` to `ST_RST_LOW` when a reset request is accepted, or to `ST_SLOT_LOW` when a write or read request is accepted.
- `ST_RST_LOW` to `ST_RST_HIGH` after the reset low time.
- `ST_RST_HIGH` to `ST_IDLE` after the high window.
- `ST_SLOT_LOW` to `ST_SLOT_HIGH` after the slot's low time.
- `ST_SLOT_HIGH` to `ST_RECOVER` at the end of the slot.
- `ST_RECOVER` to `ST_IDLE` after the recovery time.

Top module: `owm_engine`

## Requirements
- R1: After reset, `drive_n` is 1, `busy`, `done`, `presence` and `rd_bit` are 0, and no request has selected overdrive.
- R2: A reset request (`cmd_op`=0) pulls the line low (`drive_n`=0) for exactly RSTL cycles of the selected set. The pulse starts in the cycle after acceptance.
- R3: `presence` is set to the inverse of the synchronized line level MSP cycles after the reset pulse is released. It changes only at that point.
- R4: A reset keeps `busy` high for exactly RSTL + RSTH_EFF cycles. The line stays released for all of the RSTH_EFF part.
- R5: When MIXED_NET is 1, RSTH_EFF is the larger of the set's RSTH and its mixed-network floor. Otherwise RSTH_EFF is RSTH.
- R6: A write request (`cmd_op`=1) pulls the line low for W1L cycles when `cmd_bit` is 1, and for W0L cycles when `cmd_bit` is 0.
- R7: A read request (`cmd_op`=2) pulls the line low for W1L cycles. `rd_bit` then takes the synchronized line level RDS cycles after release.
- R8: A write or read slot keeps `busy` high for exactly SLOT + REC cycles, and the line is released for at least the final REC cycles.
- R9: With `cmd_od`=1 at acceptance, the overdrive set supplies every width and sample point of that request.
- R10: `busy` rises in the cycle after acceptance. Requests made while busy, and requests with `cmd_op`=3, start nothing and change no output.
- R11: `done` is a one-cycle pulse in the first idle cycle after each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request strobe, taken only when idle |
| cmd_op | input | 2 | 0 reset, 1 write, 2 read, 3 no action |
| cmd_bit | input | 1 | Bit value for a write |
| cmd_od | input | 1 | 1 selects overdrive timing for this request |
| line_in | input | 1 | Raw bus level |
| drive_n | output | 1 | Active-low pull-down enable |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Presence result of the last reset |
| rd_bit | output | 1 | Bit sampled by the last read |

## Verification
The assertions cover properties that hold on every cycle:
- every request opens with a low on the line;
- the line is never pulled while idle;
- `done` is a single pulse that coincides with `busy` falling after a released line;
- `presence` and `rd_bit` move only while the line is released inside a request.

The exact pulse widths, the busy lengths of each speed, the mixed-network stretch, and the values sampled from a slave can be shown only by the bench scenarios. These scenarios use a modelled slave, and they also check that requests made while busy or with the no-action code have no effect.

// File: rtl/owm_pkg.sv
package owm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_HIGH,
        ST_SLOT_LOW,
        ST_SLOT_HIGH,
        ST_RECOVER
    } owm_state_t;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_NONE  = 2'd3
    } owm_op_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/owm_tsel.sv
module owm_tsel import owm_pkg::*; #(
    parameter int CNT_W        = 16,
    parameter bit MIXED_NET    = 1'b0,
    parameter int STD_RSTL     = 480,
    parameter int STD_RSTH     = 480,
    parameter int MIX_STD_RSTH = 480,
    parameter int STD_MSP      = 70,
    parameter int STD_W1L      = 6,
    parameter int STD_W0L      = 60,
    parameter int STD_SLOT     = 70,
    parameter int STD_RDS      = 7,
    parameter int STD_REC      = 5,
    parameter int OD_RSTL      = 70,
    parameter int OD_RSTH      = 48,
    parameter int MIX_OD_RSTH  = 48,
    parameter int OD_MSP       = 7,
    parameter int OD_W1L       = 1,
    parameter int OD_W0L       = 6,
    parameter int OD_SLOT      = 8,
    parameter int OD_RDS       = 1,
    parameter int OD_REC       = 1
) (
    input  logic             od,
    output logic [CNT_W-1:0] rstl,
    output logic [CNT_W-1:0] rsth,
    output logic [CNT_W-1:0] msp,
    output logic [CNT_W-1:0] w1l,
    output logic [CNT_W-1:0] w0l,
    output logic [CNT_W-1:0] slot,
    output logic [CNT_W-1:0] rds,
    output logic [CNT_W-1:0] rec
);
    logic [CNT_W-1:0] rsth_std;
    logic [CNT_W-1:0] rsth_od;

    generate
        if (MIXED_NET) begin : g_mixed
            assign rsth_std = CNT_W'(imax(STD_RSTH, MIX_STD_RSTH));
            assign rsth_od  = CNT_W'(imax(OD_RSTH, MIX_OD_RSTH));
        end else begin : g_plain
            assign rsth_std = CNT_W'(STD_RSTH);
            assign rsth_od  = CNT_W'(OD_RSTH);
        end
    endgenerate

    assign rstl = od ? CNT_W'(OD_RSTL) : CNT_W'(STD_RSTL);
    assign rsth = od ? rsth_od         : rsth_std;
    assign msp  = od ? CNT_W'(OD_MSP)  : CNT_W'(STD_MSP);
    assign w1l  = od ? CNT_W'(OD_W1L)  : CNT_W'(STD_W1L);
    assign w0l  = od ? CNT_W'(OD_W0L)  : CNT_W'(STD_W0L);
    assign slot = od ? CNT_W'(OD_SLOT) : CNT_W'(STD_SLOT);
    assign rds  = od ? CNT_W'(OD_RDS)  : CNT_W'(STD_RDS);
    assign rec  = od ? CNT_W'(OD_REC)  : CNT_W'(STD_REC);
endmodule

// File: rtl/owm_engine.sv
module owm_engine import owm_pkg::*; #(
    parameter int CYC_PER_US   = 125,
    parameter bit MIXED_NET    = 1'b0,
    parameter int SYNC_STAGES  = 2,
    parameter int STD_RSTL     = 480 * CYC_PER_US,
    parameter int STD_RSTH     = 480 * CYC_PER_US,
    parameter int MIX_STD_RSTH = 480 * CYC_PER_US,
    parameter int STD_MSP      = 70 * CYC_PER_US,
    parameter int STD_W1L      = 6 * CYC_PER_US,
    parameter int STD_W0L      = 60 * CYC_PER_US,
    parameter int STD_SLOT     = 70 * CYC_PER_US,
    parameter int STD_RDS      = 7 * CYC_PER_US,
    parameter int STD_REC      = 5 * CYC_PER_US,
    parameter int OD_RSTL      = 70 * CYC_PER_US,
    parameter int OD_RSTH      = 48 * CYC_PER_US,
    parameter int MIX_OD_RSTH  = 48 * CYC_PER_US,
    parameter int OD_MSP       = 7 * CYC_PER_US,
    parameter int OD_W1L       = 1 * CYC_PER_US,
    parameter int OD_W0L       = 6 * CYC_PER_US,
    parameter int OD_SLOT      = 8 * CYC_PER_US,
    parameter int OD_RDS       = 1 * CYC_PER_US,
    parameter int OD_REC       = 1 * CYC_PER_US
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_bit,
    input  logic       cmd_od,
    input  logic       line_in,
    output logic       drive_n,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic       rd_bit
);
    localparam int MAX_STD = imax(imax(imax(STD_RSTL, STD_RSTH), MIX_STD_RSTH),
                                  imax(STD_SLOT, STD_REC));
    localparam int MAX_OD  = imax(imax(imax(OD_RSTL, OD_RSTH), MIX_OD_RSTH),
                                  imax(OD_SLOT, OD_REC));
    localparam int CNT_W   = $clog2(imax(MAX_STD, MAX_OD) + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    owm_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    owm_op_t          op_q;
    logic             od_q, bit_q, line_s;
    logic             presence_q, rd_q, done_q;
    logic [CNT_W-1:0] t_rstl, t_rsth, t_msp, t_w1l, t_w0l, t_slot, t_rds, t_rec;
    logic [CNT_W-1:0] low_len, high_len;
    logic             accept, psamp, rsamp, fin;

    owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
    );

    owm_tsel #(
        .CNT_W(CNT_W), .MIXED_NET(MIXED_NET),
        .STD_RSTL(STD_RSTL), .STD_RSTH(STD_RSTH), .MIX_STD_RSTH(MIX_STD_RSTH),
        .STD_MSP(STD_MSP), .STD_W1L(STD_W1L), .STD_W0L(STD_W0L),
        .STD_SLOT(STD_SLOT), .STD_RDS(STD_RDS), .STD_REC(STD_REC),
        .OD_RSTL(OD_RSTL), .OD_RSTH(OD_RSTH), .MIX_OD_RSTH(MIX_OD_RSTH),
        .OD_MSP(OD_MSP), .OD_W1L(OD_W1L), .OD_W0L(OD_W0L),
        .OD_SLOT(OD_SLOT), .OD_RDS(OD_RDS), .OD_REC(OD_REC)
    ) u_tsel (
        .od(od_q), .rstl(t_rstl), .rsth(t_rsth), .msp(t_msp), .w1l(t_w1l),
        .w0l(t_w0l), .slot(t_slot), .rds(t_rds), .rec(t_rec)
    );

    assign accept   = (state_q == ST_IDLE) && cmd_valid && (owm_op_t'(cmd_op) != OP_NONE);
    assign low_len  = (op_q == OP_WRITE && !bit_q) ? t_w0l : t_w1l;
    assign high_len = t_slot - low_len;
    assign psamp    = (state_q == ST_RST_HIGH) && (cnt_q == t_msp - ONE);
    assign rsamp    = (state_q == ST_SLOT_HIGH) && (op_q == OP_READ) && (cnt_q == t_rds - ONE);
    assign fin      = ((state_q == ST_RST_HIGH) && (cnt_q == t_rsth - ONE)) ||
                      ((state_q == ST_RECOVER)  && (cnt_q == t_rec - ONE));

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + ONE;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (accept)
                    state_d = (owm_op_t'(cmd_op) == OP_RESET) ? ST_RST_LOW : ST_SLOT_LOW;
            end
            ST_RST_LOW:
                if (cnt_q == t_rstl - ONE) begin
                    state_d = ST_RST_HIGH;
                    cnt_d   = '0;
                end
            ST_RST_HIGH:
                if (cnt_q == t_rsth - ONE) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            ST_SLOT_LOW:
                if (cnt_q == low_len - ONE) begin
                    state_d = ST_SLOT_HIGH;
                    cnt_d   = '0;
                end
            ST_SLOT_HIGH:
                if (cnt_q == high_len - ONE) begin
                    state_d = ST_RECOVER;
                    cnt_d   = '0;
                end
            ST_RECOVER:
                if (cnt_q == t_rec - ONE) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // request latch and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_NONE;
            od_q       <= 1'b0;
            bit_q      <= 1'b0;
            presence_q <= 1'b0;
            rd_q       <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            if (accept) begin
                op_q  <= owm_op_t'(cmd_op);
                od_q  <= cmd_od;
                bit_q <= cmd_bit;
            end
            if (psamp) presence_q <= ~line_s;
            if (rsamp) rd_q       <= line_s;
            done_q <= fin;
        end
    end

    // outputs
    always_comb begin
        drive_n  = !((state_q == ST_RST_LOW) || (state_q == ST_SLOT_LOW));
        busy     = (state_q != ST_IDLE);
        done     = done_q;
        presence = presence_q;
        rd_bit   = rd_q;
    end
endmodule

// File: rtl/owm_chk.sv
module owm_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic drive_n,
    input logic busy,
    input logic done,
    input logic presence,
    input logic rd_bit
);
    AST_LOW_OPENS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !drive_n); // R2
    AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid)); // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> drive_n); // R10
    AST_PRES_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(presence) |-> (busy && drive_n)); // R3
    AST_RD_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_bit) |-> (busy && drive_n)); // R7
    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(drive_n)); // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
endmodule

bind owm_engine owm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .drive_n(drive_n),
    .busy(busy), .done(done), .presence(presence), .rd_bit(rd_bit)
);

// File: tb/tb_owm_engine.sv
`timescale 1ns/1ps
module tb_owm_engine;
    localparam int S_RSTL = 48, S_RSTH = 40, S_MIX = 60, S_MSP = 14, S_W1L = 3,
                   S_W0L = 20, S_SLOT = 26, S_RDS = 5, S_REC = 4;
    localparam int O_RSTL = 16, O_RSTH = 20, O_MIX = 10, O_MSP = 6, O_W1L = 1,
                   O_W0L = 6, O_SLOT = 9, O_RDS = 4, O_REC = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_bit = 1'b0, cmd_od = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic drive_n, busy, done, presence, rd_bit, line;
    logic prev_drv = 1'b1;
    int   pull_cnt = 0;
    bit   slave_arm = 1'b0;
    int   slave_len = 0;
    int   n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    owm_engine #(
        .MIXED_NET(1'b1),
        .STD_RSTL(S_RSTL), .STD_RSTH(S_RSTH), .MIX_STD_RSTH(S_MIX), .STD_MSP(S_MSP),
        .STD_W1L(S_W1L), .STD_W0L(S_W0L), .STD_SLOT(S_SLOT), .STD_RDS(S_RDS), .STD_REC(S_REC),
        .OD_RSTL(O_RSTL), .OD_RSTH(O_RSTH), .MIX_OD_RSTH(O_MIX), .OD_MSP(O_MSP),
        .OD_W1L(O_W1L), .OD_W0L(O_W0L), .OD_SLOT(O_SLOT), .OD_RDS(O_RDS), .OD_REC(O_REC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .cmd_od(cmd_od), .line_in(line), .drive_n(drive_n),
        .busy(busy), .done(done), .presence(presence), .rd_bit(rd_bit)
    );

    // slave model: pulls low for slave_len cycles after the master releases
    always @(posedge clk) begin
        prev_drv <= drive_n;
        if (pull_cnt > 0) pull_cnt <= pull_cnt - 1;
        else if (!prev_drv && drive_n && slave_arm) pull_cnt <= slave_len;
    end
    assign line = drive_n && (pull_cnt == 0);

    function automatic int exp_low(int op, bit b, bit od);
        if (op == 0) return od ? O_RSTL : S_RSTL;
        if (op == 1 && !b) return od ? O_W0L : S_W0L;
        return od ? O_W1L : S_W1L;
    endfunction

    function automatic int exp_busy(int op, bit od);
        if (op == 0) return od ? (O_RSTL + ((O_RSTH > O_MIX) ? O_RSTH : O_MIX))
                               : (S_RSTL + ((S_RSTH > S_MIX) ? S_RSTH : S_MIX));
        return od ? (O_SLOT + O_REC) : (S_SLOT + S_REC);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic run_cmd(int op, bit b, bit slave_on, bit od, bit inject);
        int low = 0, first = -1, last = -1, bsy = 0, done_k = -1;
        bit busy_at_done = 1'b1;
        string tl, tb;
        slave_arm = (op == 0) ? slave_on : ((op == 2) ? !b : 1'b0);
        slave_len = (op == 0) ? ((od ? O_MSP : S_MSP) + 3) : ((od ? O_RDS : S_RDS) + 2);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bit = b; cmd_od = od;
        for (int k = 1; k < 400; k++) begin
            @(negedge clk);
            if (k == 1) cmd_valid = 1'b0;
            if (inject && k == 3) begin
                cmd_valid = 1'b1; cmd_op = 2'd0; cmd_od = !od;
            end
            if (inject && k == 4) cmd_valid = 1'b0;
            if (done) begin
                done_k = k; busy_at_done = busy;
                break;
            end
            if (!drive_n) begin
                low++;
                if (first < 0) first = k;
                last = k;
            end
            if (busy) bsy++;
        end
        tl = od ? "R9" : ((op == 0) ? "R2" : ((op == 1) ? "R6" : "R7"));
        tb = od ? "R9" : ((op == 0) ? "R4" : "R8");
        chk(first == 1, "R10", "low starts after accept", first, 1);
        chk(low == exp_low(op, b, od), tl, "low width", low, exp_low(op, b, od));
        chk(last - first + 1 == low, tl, "low contiguous", last - first + 1, low);
        chk(bsy == exp_busy(op, od), (op == 0) ? "R5" : tb, "busy length", bsy, exp_busy(op, od));
        chk(done_k == exp_busy(op, od) + 1 && !busy_at_done, "R11", "done position",
            done_k, exp_busy(op, od) + 1);
        if (op == 0) chk(presence == slave_on, "R3", "presence", presence, slave_on);
        if (op == 2) chk(rd_bit == b, "R7", "read bit", rd_bit, b);
        slave_arm = 1'b0;
        @(negedge clk);
        chk(!done, "R11", "done single pulse", done, 0);
    endtask

    task automatic run_nop();
        bit p0 = presence, r0 = rd_bit, bad = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (busy || !drive_n || done) bad = 1'b1;
        end
        chk(!bad, "R10", "op 3 started activity", bad, 0);
        chk(presence == p0 && rd_bit == r0, "R10", "op 3 changed result", presence, p0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drive_n && !busy && !done && !presence && !rd_bit, "R1", "reset state",
            {drive_n, busy, done, presence, rd_bit}, 5'b10000);
        // directed corners
        run_cmd(0, 0, 1, 0, 0);   // std reset with slave, R5 stretch
        run_cmd(0, 0, 0, 0, 0);   // no slave
        run_cmd(0, 0, 1, 1, 0);   // overdrive reset
        run_cmd(1, 1, 0, 0, 0);
        run_cmd(1, 0, 0, 0, 0);
        run_cmd(1, 0, 0, 1, 0);
        run_cmd(2, 0, 0, 0, 0);
        run_cmd(2, 1, 0, 1, 0);
        run_cmd(2, 0, 0, 1, 1);   // request while busy ignored
        run_cmd(0, 0, 1, 0, 1);
        run_nop();
        for (int i = 0; i < 40; i++) begin
            int op = int'($urandom_range(0, 2));
            run_cmd(op, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 7) == 0) run_nop();
        end
        finish_run();
    end
endmodule